// File: doc/BRIEF.md
# Address translation control sequencer

This block orders the steps of a single address translation request and reduces the outcome to one response. A request carries an effective address, an access kind (load, store or instruction fetch), an access class for data operations, the problem-state bit and the instruction-side and data-side relocate enables. The sequencer first checks whether relocation is off. If relocation is on, it asks the block translation unit, then picks a segment register from the top address bits. Next it resolves direct-store segments and the segment no-execute rule. Only when none of these ends the request does it start the page-table walker.

The two sub-units are reached through request/done handshakes and are outside this block. The response is a one-cycle pulse. It carries the physical address, the granted rights, an exception kind and a status word. A fault-address register is reloaded on every data-side fault. Only one request is in flight: a busy flag covers the span from acceptance to the response.

Top module: `xlate_seq`

## Requirements
- R1: With the relocate enable for the access side cleared (`req_ir_i` for a fetch, `req_dr_i` otherwise), the response gives physical address = effective address and rights 3'b111, and neither sub-unit is started. Kind encoding: 0 load, 1 store, 2 fetch. Rights encoding: {exec, write, read}.
- R2: With relocation on, the block translation unit is asked first. A hit ends the request with the unit's address and rights, and the walker is not started.
- R3: On a block miss, segment register `ea[31:28]` is used, and its bits [23:0] are passed to the walker as the virtual segment id.
- R4: The walker key is 1 when bit 29 of the segment is set in problem state, or when bit 30 is set in supervisor state. Otherwise it is 0.
- R5: A segment with bit 31 set and bits [28:20] = 9'h07F is a forced I/O bypass, for any access kind. The response is address {seg[3:0], ea[27:0]} with rights 3'b111.
- R6: In any other segment with bit 31 set, a fetch gives exception kind 1 (instruction) with status 32'h1000_0000.
- R7: In such a direct-store segment, an integer data access (class 0) passes with address = effective address. A load passes only with key 0 and gets rights 3'b001. A store passes only with key 1 and gets rights 3'b010. In all other cases the response is a protection fault.
- R8: Other direct-store data classes behave as follows:
  - cache operation (class 3): address = effective address, rights 0, no fault;
  - floating (class 1), and codes 5 to 7: exception kind 3 (alignment), status 0;
  - reservation (class 2): data fault with status 32'h0400_0000;
  - external (class 4): data fault with status 32'h0410_0000.
  For the data-fault statuses, 32'h0200_0000 is added for a store.
- R9: With bit 31 clear and bit 28 set in the segment, a fetch faults with kind 1 and status 32'h1000_0000, and the walker is not started. A data access proceeds to the walker with its no-execute flag set.
- R10: Walker status encoding: 0 ok, 1 not found, 2 protection.
  - ok gives the walker's address and rights with status 0.
  - not found gives 32'h4000_0000.
  - protection gives 32'h0800_0000.
  These are exception kind 1 for a fetch and kind 2 (data) for a load or store. A store adds 32'h0200_0000.
- R11: The fault address output is loaded with the effective address on every data-side fault (exception kind 2 or 3). It holds its value on instruction faults and on successes.
- R12: `req_ready_o` is high only while idle. `busy_o` is high from the cycle after acceptance until the response. `rsp_valid_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request present |
| req_ready_o | output | 1 | sequencer idle, request accepted |
| busy_o | output | 1 | request in progress |
| req_ea_i | input | 32 | effective address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| req_class_i | input | 3 | data class: 0 int, 1 float, 2 reservation, 3 cache, 4 external |
| req_pr_i | input | 1 | problem-state bit |
| req_ir_i | input | 1 | instruction relocate enable |
| req_dr_i | input | 1 | data relocate enable |
| seg_regs_i | input | 512 | 16 segment registers, register n at bits [32n+31:32n] |
| bat_req_o | output | 1 | block unit request, held until done |
| bat_ea_o | output | 32 | address to block unit |
| bat_kind_o | output | 2 | access kind to block unit |
| bat_pr_o | output | 1 | problem state to block unit |
| bat_done_i | input | 1 | block unit answer valid |
| bat_hit_i | input | 1 | block hit with rights granted |
| bat_pa_i | input | 32 | block physical address |
| bat_rights_i | input | 3 | block rights |
| walk_req_o | output | 1 | walker request, held until done |
| walk_ea_o | output | 32 | address to walker |
| walk_vsid_o | output | 24 | virtual segment id |
| walk_key_o | output | 1 | protection key |
| walk_nx_o | output | 1 | segment no-execute flag |
| walk_kind_o | output | 2 | access kind to walker |
| walk_done_i | input | 1 | walker answer valid |
| walk_status_i | input | 2 | 0 ok, 1 not found, 2 protection |
| walk_pa_i | input | 32 | walker physical address |
| walk_rights_i | input | 3 | walker rights |
| rsp_valid_o | output | 1 | response pulse |
| rsp_pa_o | output | 32 | physical address |
| rsp_rights_o | output | 3 | granted rights {x,w,r} |
| rsp_exc_o | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| rsp_status_o | output | 32 | fault status word |
| rsp_dar_o | output | 32 | captured data fault address |

## Verification
The hardest outcomes to reach are the direct-store classes and the walker faults. Each needs relocation on, a block-unit miss and a segment register crafted for that branch, with the right pairing of key, problem state and access direction. The bench models both sub-units behind their handshakes, with a per-scenario hit or status setting, and counts how often each is started. That lets a no-execute fetch or a bypass be shown to end before any table walk. The fault-address output is followed across a mix of instruction and data faults, to show that only data-side faults reload it.

// File: rtl/xlate_seq_pkg.sv
package xlate_seq_pkg;
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLOAT = 3'd1;
  localparam logic [2:0] CLS_RESV  = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  localparam logic [1:0] EXC_NONE  = 2'd0;
  localparam logic [1:0] EXC_ISI   = 2'd1;
  localparam logic [1:0] EXC_DSI   = 2'd2;
  localparam logic [1:0] EXC_ALIGN = 2'd3;

  localparam logic [1:0] WST_OK   = 2'd0;
  localparam logic [1:0] WST_MISS = 2'd1;

  localparam int          ST_W         = 32;
  localparam int          BUS_ID_W     = 9;
  localparam logic [8:0]  FORCED_IO_ID = 9'h07F;

  localparam logic [31:0] STW_MISS   = 32'h4000_0000;
  localparam logic [31:0] STW_PROT   = 32'h0800_0000;
  localparam logic [31:0] STW_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] STW_RESV   = 32'h0400_0000;
  localparam logic [31:0] STW_EXT    = 32'h0410_0000;
  localparam logic [31:0] STW_STORE  = 32'h0200_0000;

  typedef enum logic [2:0] {
    CAUSE_NONE, CAUSE_MISS, CAUSE_PROT, CAUSE_NOEXEC,
    CAUSE_ALIGN, CAUSE_RESV, CAUSE_EXT
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_BAT, ST_SEG, ST_WALK
  } state_e;
endpackage

// File: rtl/xlate_seg_decode.sv
module xlate_seg_decode
  import xlate_seq_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 32,
  parameter int VSID_W  = 24,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG*SEG_W-1:0] seg_regs_i,
  input  logic [SEL_W-1:0]         seg_sel_i,
  input  logic                     pr_i,
  output logic                     dstore_o,
  output logic                     nx_o,
  output logic                     key_o,
  output logic [VSID_W-1:0]        vsid_o,
  output logic [BUS_ID_W-1:0]      bus_id_o,
  output logic [3:0]               io_hi_o
);
  localparam int T_BIT  = SEG_W - 1;
  localparam int KS_BIT = SEG_W - 2;
  localparam int KP_BIT = SEG_W - 3;
  localparam int NX_BIT = SEG_W - 4;

  logic [SEG_W-1:0] seg_arr [NUM_SEG];
  logic [SEG_W-1:0] seg;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
    assign seg_arr[g] = seg_regs_i[g*SEG_W +: SEG_W];
  end

  assign seg      = seg_arr[seg_sel_i];
  assign dstore_o = seg[T_BIT];
  assign nx_o     = seg[NX_BIT];
  // key from user-key in problem state, supervisor-key otherwise
  assign key_o    = pr_i ? seg[KP_BIT] : seg[KS_BIT];
  assign vsid_o   = seg[VSID_W-1:0];
  assign bus_id_o = seg[NX_BIT -: BUS_ID_W];
  assign io_hi_o  = seg[3:0];
endmodule

// File: rtl/xlate_ds_check.sv
module xlate_ds_check
  import xlate_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]       ea_i,
  input  logic [BUS_ID_W-1:0] bus_id_i,
  input  logic [3:0]          io_hi_i,
  input  logic [1:0]          kind_i,
  input  logic [2:0]          cls_i,
  input  logic                key_i,
  output logic [AW-1:0]       pa_o,
  output logic [2:0]          rights_o,
  output cause_e              cause_o
);
  logic is_fetch, is_store, forced;

  assign is_fetch = (kind_i == KIND_FETCH);
  assign is_store = (kind_i == KIND_STORE);
  assign forced   = (bus_id_i == FORCED_IO_ID);

  always_comb begin
    pa_o     = ea_i;
    rights_o = 3'b000;
    cause_o  = CAUSE_NONE;
    if (forced) begin
      pa_o     = {io_hi_i, ea_i[AW-5:0]};
      rights_o = 3'b111;
    end else if (is_fetch) begin
      cause_o = CAUSE_NOEXEC;
    end else begin
      case (cls_i)
        CLS_INT: begin
          if (!is_store && !key_i)     rights_o = 3'b001;
          else if (is_store && key_i)  rights_o = 3'b010;
          else                         cause_o  = CAUSE_PROT;
        end
        CLS_CACHE: rights_o = 3'b000;
        CLS_RESV:  cause_o  = CAUSE_RESV;
        CLS_EXT:   cause_o  = CAUSE_EXT;
        default:   cause_o  = CAUSE_ALIGN;
      endcase
    end
  end
endmodule

// File: rtl/xlate_fault_enc.sv
module xlate_fault_enc
  import xlate_seq_pkg::*;
(
  input  cause_e          cause_i,
  input  logic            fetch_i,
  input  logic            store_i,
  output logic [1:0]      exc_o,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] st_add;

  assign st_add = store_i ? STW_STORE : '0;

  always_comb begin
    exc_o    = EXC_NONE;
    status_o = '0;
    if (cause_i != CAUSE_NONE) begin
      if (fetch_i) begin
        exc_o = EXC_ISI;
        case (cause_i)
          CAUSE_MISS: status_o = STW_MISS;
          CAUSE_PROT: status_o = STW_PROT;
          default:    status_o = STW_NOEXEC;
        endcase
      end else begin
        exc_o = EXC_DSI;
        case (cause_i)
          CAUSE_MISS:  status_o = STW_MISS | st_add;
          CAUSE_RESV:  status_o = STW_RESV | st_add;
          CAUSE_EXT:   status_o = STW_EXT | st_add;
          CAUSE_ALIGN: begin
            exc_o    = EXC_ALIGN;
            status_o = '0;
          end
          default:     status_o = STW_PROT | st_add;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_seq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 32,
  parameter int VSID_W  = 24,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  output logic                     busy_o,
  input  logic [AW-1:0]            req_ea_i,
  input  logic [1:0]               req_kind_i,
  input  logic [2:0]               req_class_i,
  input  logic                     req_pr_i,
  input  logic                     req_ir_i,
  input  logic                     req_dr_i,
  input  logic [NUM_SEG*SEG_W-1:0] seg_regs_i,
  output logic                     bat_req_o,
  output logic [AW-1:0]            bat_ea_o,
  output logic [1:0]               bat_kind_o,
  output logic                     bat_pr_o,
  input  logic                     bat_done_i,
  input  logic                     bat_hit_i,
  input  logic [AW-1:0]            bat_pa_i,
  input  logic [2:0]               bat_rights_i,
  output logic                     walk_req_o,
  output logic [AW-1:0]            walk_ea_o,
  output logic [VSID_W-1:0]        walk_vsid_o,
  output logic                     walk_key_o,
  output logic                     walk_nx_o,
  output logic [1:0]               walk_kind_o,
  input  logic                     walk_done_i,
  input  logic [1:0]               walk_status_i,
  input  logic [AW-1:0]            walk_pa_i,
  input  logic [2:0]               walk_rights_i,
  output logic                     rsp_valid_o,
  output logic [AW-1:0]            rsp_pa_o,
  output logic [2:0]               rsp_rights_o,
  output logic [1:0]               rsp_exc_o,
  output logic [ST_W-1:0]          rsp_status_o,
  output logic [AW-1:0]            rsp_dar_o
);
  state_e state_q, state_d;

  logic [AW-1:0] ea_q;
  logic [1:0]    kind_q;
  logic [2:0]    cls_q;
  logic          pr_q, ir_q, dr_q;

  logic accept, is_fetch, is_store, real_mode;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign is_fetch  = (kind_q == KIND_FETCH);
  assign is_store  = (kind_q == KIND_STORE);
  assign real_mode = is_fetch ? !ir_q : !dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= '0;
      kind_q <= KIND_LOAD;
      cls_q  <= CLS_INT;
      pr_q   <= 1'b0;
      ir_q   <= 1'b0;
      dr_q   <= 1'b0;
    end else if (accept) begin
      ea_q   <= req_ea_i;
      kind_q <= req_kind_i;
      cls_q  <= req_class_i;
      pr_q   <= req_pr_i;
      ir_q   <= req_ir_i;
      dr_q   <= req_dr_i;
    end
  end

  // segment decode
  logic                seg_ds, seg_nx, seg_key;
  logic [VSID_W-1:0]   seg_vsid;
  logic [BUS_ID_W-1:0] seg_bus;
  logic [3:0]          seg_io_hi;

  xlate_seg_decode #(
    .NUM_SEG (NUM_SEG),
    .SEG_W   (SEG_W),
    .VSID_W  (VSID_W)
  ) u_seg (
    .seg_regs_i (seg_regs_i),
    .seg_sel_i  (ea_q[AW-1 -: SEL_W]),
    .pr_i       (pr_q),
    .dstore_o   (seg_ds),
    .nx_o       (seg_nx),
    .key_o      (seg_key),
    .vsid_o     (seg_vsid),
    .bus_id_o   (seg_bus),
    .io_hi_o    (seg_io_hi)
  );

  // direct-store outcome
  logic [AW-1:0] ds_pa;
  logic [2:0]    ds_rights;
  cause_e        ds_cause;

  xlate_ds_check #(.AW(AW)) u_ds (
    .ea_i     (ea_q),
    .bus_id_i (seg_bus),
    .io_hi_i  (seg_io_hi),
    .kind_i   (kind_q),
    .cls_i    (cls_q),
    .key_i    (seg_key),
    .pa_o     (ds_pa),
    .rights_o (ds_rights),
    .cause_o  (ds_cause)
  );

  // sequencing
  logic          fin;
  logic [AW-1:0] fin_pa;
  logic [2:0]    fin_rights;
  cause_e        fin_cause;

  always_comb begin
    state_d    = state_q;
    fin        = 1'b0;
    fin_pa     = ea_q;
    fin_rights = 3'b000;
    fin_cause  = CAUSE_NONE;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (real_mode) begin
          fin        = 1'b1;
          fin_rights = 3'b111;
        end else begin
          state_d = ST_BAT;
        end
      end
      ST_BAT: begin
        if (bat_done_i) begin
          if (bat_hit_i) begin
            fin        = 1'b1;
            fin_pa     = bat_pa_i;
            fin_rights = bat_rights_i;
          end else begin
            state_d = ST_SEG;
          end
        end
      end
      ST_SEG: begin
        if (seg_ds) begin
          fin        = 1'b1;
          fin_pa     = ds_pa;
          fin_rights = ds_rights;
          fin_cause  = ds_cause;
        end else if (seg_nx && is_fetch) begin
          fin       = 1'b1;
          fin_cause = CAUSE_NOEXEC;
        end else begin
          state_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (walk_done_i) begin
          fin = 1'b1;
          case (walk_status_i)
            WST_OK: begin
              fin_pa     = walk_pa_i;
              fin_rights = walk_rights_i;
            end
            WST_MISS: fin_cause = CAUSE_MISS;
            default:  fin_cause = CAUSE_PROT;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // fault classification
  logic [1:0]      enc_exc;
  logic [ST_W-1:0] enc_status;

  xlate_fault_enc u_enc (
    .cause_i  (fin_cause),
    .fetch_i  (is_fetch),
    .store_i  (is_store),
    .exc_o    (enc_exc),
    .status_o (enc_status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_pa_o     <= '0;
      rsp_rights_o <= '0;
      rsp_exc_o    <= EXC_NONE;
      rsp_status_o <= '0;
      rsp_dar_o    <= '0;
    end else begin
      rsp_valid_o <= fin;
      if (fin) begin
        rsp_pa_o     <= fin_pa;
        rsp_rights_o <= fin_rights;
        rsp_exc_o    <= enc_exc;
        rsp_status_o <= enc_status;
        if (enc_exc == EXC_DSI || enc_exc == EXC_ALIGN) rsp_dar_o <= ea_q;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);

  assign bat_req_o   = (state_q == ST_BAT);
  assign bat_ea_o    = ea_q;
  assign bat_kind_o  = kind_q;
  assign bat_pr_o    = pr_q;

  assign walk_req_o  = (state_q == ST_WALK);
  assign walk_ea_o   = ea_q;
  assign walk_vsid_o = seg_vsid;
  assign walk_key_o  = seg_key;
  assign walk_nx_o   = seg_nx;
  assign walk_kind_o = kind_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i) |=> busy_o); // R12
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R12
  AST_REAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && real_mode) |=>
      (rsp_valid_o && rsp_rights_o == 3'b111 && rsp_pa_o == $past(ea_q))); // R1
  AST_NX_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEG && !seg_ds && seg_nx && is_fetch) |=>
      (!walk_req_o && rsp_exc_o == EXC_ISI)); // R9
  AST_WALK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && walk_done_i) |=> rsp_valid_o); // R10
  AST_OK_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_exc_o == EXC_NONE) |-> (rsp_status_o == '0)); // R10
  AST_ISI_KEEPS_DAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_exc_o == EXC_ISI) |-> $stable(rsp_dar_o)); // R11
endmodule

// File: tb/xlate_seq_tb_top.sv
module xlate_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        req_valid_i = 1'b0;
  logic        req_ready_o, busy_o;
  logic [31:0] req_ea_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic [2:0]  req_class_i = '0;
  logic        req_pr_i = 1'b0, req_ir_i = 1'b0, req_dr_i = 1'b0;
  logic [511:0] seg_flat = '0;
  logic        bat_req_o, bat_pr_o;
  logic [31:0] bat_ea_o;
  logic [1:0]  bat_kind_o;
  logic        bat_done_i = 1'b0;
  logic        bat_hit_i = 1'b0;
  logic [31:0] bat_pa_i = '0;
  logic [2:0]  bat_rights_i = '0;
  logic        walk_req_o, walk_key_o, walk_nx_o;
  logic [31:0] walk_ea_o;
  logic [23:0] walk_vsid_o;
  logic [1:0]  walk_kind_o;
  logic        walk_done_i = 1'b0;
  logic [1:0]  walk_status_i = '0;
  logic [31:0] walk_pa_i = '0;
  logic [2:0]  walk_rights_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_pa_o, rsp_status_o, rsp_dar_o;
  logic [2:0]  rsp_rights_o;
  logic [1:0]  rsp_exc_o;

  xlate_seq dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .busy_o, .req_ea_i, .req_kind_i,
    .req_class_i, .req_pr_i, .req_ir_i, .req_dr_i, .seg_regs_i(seg_flat),
    .bat_req_o, .bat_ea_o, .bat_kind_o, .bat_pr_o, .bat_done_i, .bat_hit_i,
    .bat_pa_i, .bat_rights_i, .walk_req_o, .walk_ea_o, .walk_vsid_o, .walk_key_o,
    .walk_nx_o, .walk_kind_o, .walk_done_i, .walk_status_i, .walk_pa_i,
    .walk_rights_i, .rsp_valid_o, .rsp_pa_o, .rsp_rights_o, .rsp_exc_o,
    .rsp_status_o, .rsp_dar_o
  );

  int n_checks = 0, n_fail = 0;
  int bat_calls = 0, walk_calls = 0;
  logic [23:0] w_vsid;
  logic        w_key, w_nx;
  logic [31:0] g_pa, g_status, g_dar;
  logic [2:0]  g_rights;
  logic [1:0]  g_exc;
  logic [31:0] exp_dar = '0;

  // sub-unit models: answer one cycle after a request is seen
  always @(negedge clk_i) begin
    bat_done_i  <= 1'b0;
    walk_done_i <= 1'b0;
    if (bat_req_o && !bat_done_i) begin
      bat_done_i <= 1'b1;
      bat_calls++;
    end
    if (walk_req_o && !walk_done_i) begin
      walk_done_i <= 1'b1;
      walk_calls++;
      w_vsid = walk_vsid_o;
      w_key  = walk_key_o;
      w_nx   = walk_nx_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_seg(input int idx, input logic [31:0] v);
    seg_flat[idx*32 +: 32] = v;
  endtask

  task automatic run_req(input logic [31:0] ea, input logic [1:0] kind, input logic [2:0] cls,
                         input logic pr, input logic ir, input logic dr);
    int waited;
    @(negedge clk_i);
    req_ea_i = ea; req_kind_i = kind; req_class_i = cls;
    req_pr_i = pr; req_ir_i = ir; req_dr_i = dr;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    chk("R12 busy after accept", {31'd0, busy_o}, 32'd1);
    chk("R12 ready low while busy", {31'd0, req_ready_o}, 32'd0);
    waited = 0;
    while (waited < 40) begin
      @(negedge clk_i);
      if (rsp_valid_o) break;
      waited++;
    end
    chk("R12 response seen", {31'd0, rsp_valid_o}, 32'd1);
    chk("R12 not busy at response", {31'd0, busy_o}, 32'd0);
    g_pa = rsp_pa_o; g_rights = rsp_rights_o; g_exc = rsp_exc_o;
    g_status = rsp_status_o; g_dar = rsp_dar_o;
    @(negedge clk_i);
    chk("R12 response one cycle", {31'd0, rsp_valid_o}, 32'd0);
  endtask

  task automatic expect_rsp(input string tag, input logic [31:0] pa, input logic [2:0] rights,
                            input logic [1:0] exc, input logic [31:0] status);
    if (exc == 2'd0) chk({tag, " pa"}, g_pa, pa);
    if (exc == 2'd0) chk({tag, " rights"}, {29'd0, g_rights}, {29'd0, rights});
    chk({tag, " exc"}, {30'd0, g_exc}, {30'd0, exc});
    chk({tag, " status"}, g_status, status);
    chk("R11 fault address", g_dar, exp_dar);
  endtask

  task automatic t_reset;
    chk("R12 reset ready", {31'd0, req_ready_o}, 32'd1);
    chk("R12 reset busy", {31'd0, busy_o}, 32'd0);
    chk("R12 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    chk("R11 reset dar", rsp_dar_o, 32'd0);
    chk("R2 reset no bat req", {31'd0, bat_req_o}, 32'd0);
  endtask

  task automatic t_real;
    int b0;
    b0 = bat_calls;
    run_req(32'h1234_5678, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0);
    expect_rsp("R1 real load", 32'h1234_5678, 3'b111, 2'd0, 32'd0);
    run_req(32'hFEDC_0004, 2'd2, 3'd0, 1'b1, 1'b0, 1'b1);
    expect_rsp("R1 real fetch", 32'hFEDC_0004, 3'b111, 2'd0, 32'd0);
    chk("R1 no block lookup", bat_calls, b0);
    // instruction relocate on, data off: fetch translates
    bat_hit_i = 1'b1; bat_pa_i = 32'h0770_0000; bat_rights_i = 3'b101;
    run_req(32'h0000_0100, 2'd2, 3'd0, 1'b0, 1'b1, 1'b0);
    chk("R1 fetch uses ir side", bat_calls, b0 + 1);
    bat_hit_i = 1'b0;
  endtask

  task automatic t_bat;
    int w0;
    w0 = walk_calls;
    bat_hit_i = 1'b1; bat_pa_i = 32'h0ABC_D123; bat_rights_i = 3'b011;
    run_req(32'h2000_0123, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R2 block hit", 32'h0ABC_D123, 3'b011, 2'd0, 32'd0);
    chk("R2 no walk on hit", walk_calls, w0);
    bat_hit_i = 1'b0;
  endtask

  task automatic t_walk;
    int w0;
    set_seg(5, 32'h400A_BCDE);
    walk_status_i = 2'd0; walk_pa_i = 32'h0055_5004; walk_rights_i = 3'b101;
    w0 = walk_calls;
    run_req(32'h5000_3004, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 walk ok", 32'h0055_5004, 3'b101, 2'd0, 32'd0);
    chk("R3 walk started", walk_calls, w0 + 1);
    chk("R3 vsid", {8'd0, w_vsid}, 32'h000A_BCDE);
    chk("R4 key supervisor ks", {31'd0, w_key}, 32'd1);
    run_req(32'h5000_3004, 2'd0, 3'd0, 1'b1, 1'b1, 1'b1);
    chk("R4 key problem no kp", {31'd0, w_key}, 32'd0);
    set_seg(5, 32'h200A_BCDE);
    run_req(32'h5000_3004, 2'd0, 3'd0, 1'b1, 1'b1, 1'b1);
    chk("R4 key problem kp", {31'd0, w_key}, 32'd1);
    set_seg(7, 32'h0000_0777);
    run_req(32'h7000_0000, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    chk("R3 other segment vsid", {8'd0, w_vsid}, 32'h0000_0777);
  endtask

  task automatic t_forced_io;
    int w0;
    w0 = walk_calls;
    set_seg(10, 32'h87F0_0009);
    run_req(32'hA123_4567, 2'd2, 3'd0, 1'b1, 1'b1, 1'b1);
    expect_rsp("R5 forced io fetch", 32'h9123_4567, 3'b111, 2'd0, 32'd0);
    run_req(32'hAFFF_FFF0, 2'd1, 3'd1, 1'b0, 1'b1, 1'b1);
    expect_rsp("R5 forced io store", 32'h9FFF_FFF0, 3'b111, 2'd0, 32'd0);
    chk("R5 no walk", walk_calls, w0);
  endtask

  task automatic t_ds;
    int w0;
    w0 = walk_calls;
    set_seg(11, 32'h8000_0000);
    run_req(32'hB000_0010, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R6 ds fetch", 32'd0, 3'd0, 2'd1, 32'h1000_0000);
    run_req(32'hB000_0020, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R7 int load key0", 32'hB000_0020, 3'b001, 2'd0, 32'd0);
    exp_dar = 32'hB000_0030;
    run_req(32'hB000_0030, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R7 int store key0", 32'd0, 3'd0, 2'd2, 32'h0A00_0000);
    set_seg(11, 32'hC000_0000);
    exp_dar = 32'hB000_0040;
    run_req(32'hB000_0040, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R7 int load key1", 32'd0, 3'd0, 2'd2, 32'h0800_0000);
    run_req(32'hB000_0050, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R7 int store key1", 32'hB000_0050, 3'b010, 2'd0, 32'd0);
    run_req(32'hB000_0060, 2'd0, 3'd3, 1'b0, 1'b1, 1'b1);
    expect_rsp("R8 cache op", 32'hB000_0060, 3'b000, 2'd0, 32'd0);
    exp_dar = 32'hB000_0070;
    run_req(32'hB000_0070, 2'd0, 3'd1, 1'b0, 1'b1, 1'b1);
    expect_rsp("R8 float", 32'd0, 3'd0, 2'd3, 32'd0);
    exp_dar = 32'hB000_0080;
    run_req(32'hB000_0080, 2'd1, 3'd2, 1'b0, 1'b1, 1'b1);
    expect_rsp("R8 reservation store", 32'd0, 3'd0, 2'd2, 32'h0600_0000);
    exp_dar = 32'hB000_0090;
    run_req(32'hB000_0090, 2'd0, 3'd4, 1'b0, 1'b1, 1'b1);
    expect_rsp("R8 external load", 32'd0, 3'd0, 2'd2, 32'h0410_0000);
    exp_dar = 32'hB000_00A0;
    run_req(32'hB000_00A0, 2'd0, 3'd6, 1'b0, 1'b1, 1'b1);
    expect_rsp("R8 unknown class", 32'd0, 3'd0, 2'd3, 32'd0);
    chk("R6 no walk in ds", walk_calls, w0);
  endtask

  task automatic t_noexec;
    int w0;
    set_seg(3, 32'h1000_0042);
    w0 = walk_calls;
    run_req(32'h3000_0000, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R9 nx fetch", 32'd0, 3'd0, 2'd1, 32'h1000_0000);
    chk("R9 no walk on nx fetch", walk_calls, w0);
    walk_status_i = 2'd0; walk_pa_i = 32'h0001_2000; walk_rights_i = 3'b011;
    run_req(32'h3000_0400, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R9 nx data walks", 32'h0001_2000, 3'b011, 2'd0, 32'd0);
    chk("R9 walk started", walk_calls, w0 + 1);
    chk("R9 walk nx flag", {31'd0, w_nx}, 32'd1);
  endtask

  task automatic t_walk_faults;
    set_seg(6, 32'h0000_0123);
    walk_status_i = 2'd1;
    run_req(32'h6000_0000, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 fetch miss", 32'd0, 3'd0, 2'd1, 32'h4000_0000);
    exp_dar = 32'h6000_0ABC;
    run_req(32'h6000_0ABC, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 store miss", 32'd0, 3'd0, 2'd2, 32'h4200_0000);
    walk_status_i = 2'd2;
    exp_dar = 32'h6000_1000;
    run_req(32'h6000_1000, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 load prot", 32'd0, 3'd0, 2'd2, 32'h0800_0000);
    run_req(32'h6000_2000, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 fetch prot", 32'd0, 3'd0, 2'd1, 32'h0800_0000);
    exp_dar = 32'h6000_3000;
    run_req(32'h6000_3000, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
    expect_rsp("R10 store prot", 32'd0, 3'd0, 2'd2, 32'h0A00_0000);
    walk_status_i = 2'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    t_real();
    t_bat();
    t_walk();
    t_forced_io();
    t_ds();
    t_noexec();
    t_walk_faults();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule